// File: doc/BRIEF.md
# Multi-Size ALU Flag Unit

This block is the arithmetic and condition-code slice of a 16/32-bit processor core. A combinational datapath adds, subtracts, compares or negates two operands at byte, word or longword size, and derives the half-carry, negative, zero, overflow and carry flags for that size. A registered 8-bit condition code register (CCR) captures those flags on the clock edge. It also takes software writes (load, AND, OR and XOR with an immediate) and a hardware exception-entry strobe that raises the interrupt mask.

The operation takes a destination operand and a source operand. The sum or difference replaces only the low byte, word or longword of the destination. Bits above the selected size come out unchanged from the destination. The extend variants add or subtract a carry-in. They chain the zero flag across the pieces of a multi-precision value. The interrupt-acceptance output combines the mask bit with a maskable request and a non-maskable request. Reading the CCR for a store is done through the `ccr` output.

Top module: `alu_flag_unit`

## Requirements
- R1: While reset is held and right after it, `ccr` is 8'h80: the mask bit I (bit 7) is 1 and every other bit is 0. CCR layout, from bit 7 down: I, UI, H, U, N, Z, V, C.
- R2: With `op_valid` high, `result` is `dst_op` op `src_op` on the low 8 (size 0), 16 (size 1) or 32 (size 2 or 3) bits, and the remaining upper bits equal `dst_op`. Op codes: 0 add, 1 add-with-extend (+cin), 2 subtract, 3 subtract-with-extend (-cin), 4 compare (dst-src), 5 negate (0-dst), 6 and 7 no operation.
- R3: On an arithmetic operation C (bit 0) takes the carry, or for subtract, compare and negate the borrow, out of the most significant bit of the selected size.
- R4: H (bit 5) takes the carry or borrow out of bit 3 at byte size, bit 11 at word size and bit 27 at longword size. Every arithmetic op updates it at byte size. At word and longword size the extend variants leave H unchanged.
- R5: N (bit 3) takes the most significant bit of the result at the selected size.
- R6: For add, subtract, compare and negate, Z (bit 2) is set when the sized result is zero and cleared otherwise. For the extend variants, Z keeps its value on a zero result and is cleared on a non-zero one.
- R7: V (bit 1) is set when the signed result at the selected size overflows and cleared otherwise.
- R8: `result_we` is high for op codes 0, 1, 2, 3 and 5 when `op_valid` is high, and low otherwise. Compare updates flags only.
- R9: `ccr_mode` 1 loads `ccr_imm`, 2 ANDs it, 3 ORs it and 4 XORs it into the CCR at the next edge (0 and 5 to 7: no write). A write takes precedence over a flag update in the same cycle. UI (bit 6) and U (bit 4) change only through these writes.
- R10: `exc_entry` sets I at the next edge, overriding a same-cycle write or flag update of that bit.
- R11: `int_accept` is high in the same cycle whenever `nmi_req` is high, or when `irq_req` is high and I is 0. UI has no effect on it.
- R12: With `op_valid` low or a no-operation code, `ccr_mode` 0 and `exc_entry` low, the CCR holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_op | input | 32 | Source operand |
| dst_op | input | 32 | Destination operand, also the upper-bit pass-through |
| size | input | 2 | Operand size: 0 byte, 1 word, 2/3 longword |
| op | input | 3 | Operation code |
| op_valid | input | 1 | Operation present this cycle |
| cin | input | 1 | Carry/borrow in for the extend variants |
| ccr_mode | input | 3 | CCR write mode |
| ccr_imm | input | 8 | Immediate for CCR writes |
| exc_entry | input | 1 | Exception-entry strobe, sets I |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| result | output | 32 | Sized result merged with destination upper bits |
| result_we | output | 1 | Result write enable |
| ccr | output | 8 | Condition code register |
| int_accept | output | 1 | Interrupt accepted |

## Verification
`result`, `result_we` and `int_accept` are combinational and are due in the same cycle as their inputs. The CCR is due one rising edge after an operation, a write or the exception strobe. The bench changes inputs on the falling edge and samples the combinational outputs 1 ns later. It samples `ccr` 1 ns after the following rising edge, so each check lands on the one cycle in which its value is defined. A bench model computes the expected flags from the sized operands with comparisons and exact signed sums, not with bit-position carry logic.

// File: rtl/afu_pkg.sv
package afu_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_LALT = 2'd3
   } size_e;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_ADDX = 3'd1,
      OP_SUB  = 3'd2,
      OP_SUBX = 3'd3,
      OP_CMP  = 3'd4,
      OP_NEG  = 3'd5,
      OP_RSV  = 3'd6,
      OP_NOP  = 3'd7
   } op_e;

   typedef enum logic [2:0] {
      CW_NONE = 3'd0,
      CW_LOAD = 3'd1,
      CW_AND  = 3'd2,
      CW_OR   = 3'd3,
      CW_XOR  = 3'd4
   } ccrw_e;

   localparam int unsigned BIT_I  = 7;
   localparam int unsigned BIT_UI = 6;
   localparam int unsigned BIT_H  = 5;
   localparam int unsigned BIT_U  = 4;
   localparam int unsigned BIT_N  = 3;
   localparam int unsigned BIT_Z  = 2;
   localparam int unsigned BIT_V  = 1;
   localparam int unsigned BIT_C  = 0;

   localparam logic [7:0] CCR_RST = 8'h80;
endpackage

// File: rtl/afu_opdec.sv
module afu_opdec
   import afu_pkg::*;
(
   input  logic [2:0] op_i,
   input  logic [1:0] size_i,
   input  logic       valid_i,
   input  logic       cin_i,
   output logic       sub_o,
   output logic       neg_o,
   output logic       cin_o,
   output logic       we_o,
   output logic       upd_o,
   output logic       ext_o,
   output logic       h_upd_o
);
   logic arith;

   always_comb begin
      arith = 1'b0;
      sub_o = 1'b0;
      neg_o = 1'b0;
      ext_o = 1'b0;
      case (op_i)
         OP_ADD:  arith = 1'b1;
         OP_ADDX: begin arith = 1'b1; ext_o = 1'b1; end
         OP_SUB:  begin arith = 1'b1; sub_o = 1'b1; end
         OP_SUBX: begin arith = 1'b1; sub_o = 1'b1; ext_o = 1'b1; end
         OP_CMP:  begin arith = 1'b1; sub_o = 1'b1; end
         OP_NEG:  begin arith = 1'b1; sub_o = 1'b1; neg_o = 1'b1; end
         default: arith = 1'b0;
      endcase
      cin_o   = ext_o & cin_i;
      upd_o   = valid_i & arith;
      we_o    = upd_o & (op_i != OP_CMP);
      h_upd_o = upd_o & ((size_i == SZ_BYTE) | ~ext_o);
   end
endmodule

// File: rtl/afu_arith.sv
module afu_arith
   import afu_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned HC_OFS = 4
)(
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic [1:0]        size_i,
   input  logic              sub_i,
   input  logic              neg_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] res_o,
   output logic              h_o,
   output logic              n_o,
   output logic              zero_o,
   output logic              v_o,
   output logic              c_o
);
   localparam int unsigned LANES  = 3;
   localparam int unsigned BYTE_W = DATA_W / 4;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int unsigned W  = BYTE_W << k;
      localparam int unsigned HP = W - 1 - HC_OFS;

      logic [W-1:0]      x, y;
      logic [W:0]        full;
      logic [HP+1:0]     half;
      logic [DATA_W-1:0] res;
      logic              h, n, zero, v, c;

      always_comb begin
         x    = neg_i ? '0 : dst_i[W-1:0];
         y    = neg_i ? dst_i[W-1:0] : src_i[W-1:0];
         if (sub_i) begin
            full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin_i};
            half = {1'b0, x[HP:0]} - {1'b0, y[HP:0]} - {{(HP+1){1'b0}}, cin_i};
            v    = (x[W-1] != y[W-1]) & (full[W-1] != x[W-1]);
         end else begin
            full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin_i};
            half = {1'b0, x[HP:0]} + {1'b0, y[HP:0]} + {{(HP+1){1'b0}}, cin_i};
            v    = (x[W-1] == y[W-1]) & (full[W-1] != x[W-1]);
         end
         res        = dst_i;
         res[W-1:0] = full[W-1:0];
         c          = full[W];
         h          = half[HP+1];
         n          = full[W-1];
         zero       = (full[W-1:0] == '0);
      end
   end

   always_comb begin
      case (size_i)
         SZ_BYTE: begin
            res_o = g_lane[0].res; h_o = g_lane[0].h; n_o = g_lane[0].n;
            zero_o = g_lane[0].zero; v_o = g_lane[0].v; c_o = g_lane[0].c;
         end
         SZ_WORD: begin
            res_o = g_lane[1].res; h_o = g_lane[1].h; n_o = g_lane[1].n;
            zero_o = g_lane[1].zero; v_o = g_lane[1].v; c_o = g_lane[1].c;
         end
         default: begin
            res_o = g_lane[2].res; h_o = g_lane[2].h; n_o = g_lane[2].n;
            zero_o = g_lane[2].zero; v_o = g_lane[2].v; c_o = g_lane[2].c;
         end
      endcase
   end
endmodule

// File: rtl/afu_ccr.sv
module afu_ccr
   import afu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd_i,
   input  logic       h_upd_i,
   input  logic       ext_i,
   input  logic       h_i,
   input  logic       n_i,
   input  logic       zero_i,
   input  logic       v_i,
   input  logic       c_i,
   input  logic [2:0] wmode_i,
   input  logic [7:0] imm_i,
   input  logic       exc_i,
   output logic [7:0] ccr_o
);
   logic [7:0] ccr_q, ccr_d;

   always_comb begin
      ccr_d = ccr_q;
      case (wmode_i)
         CW_LOAD: ccr_d = imm_i;
         CW_AND:  ccr_d = ccr_q & imm_i;
         CW_OR:   ccr_d = ccr_q | imm_i;
         CW_XOR:  ccr_d = ccr_q ^ imm_i;
         default: begin
            if (upd_i) begin
               if (h_upd_i) ccr_d[BIT_H] = h_i;
               ccr_d[BIT_N] = n_i;
               ccr_d[BIT_Z] = ext_i ? (zero_i & ccr_q[BIT_Z]) : zero_i;
               ccr_d[BIT_V] = v_i;
               ccr_d[BIT_C] = c_i;
            end
         end
      endcase
      if (exc_i) ccr_d[BIT_I] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ccr_q <= CCR_RST;
      else        ccr_q <= ccr_d;
   end

   assign ccr_o = ccr_q;
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import afu_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned HC_OFS = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src_op,
   input  logic [DATA_W-1:0] dst_op,
   input  logic [1:0]        size,
   input  logic [2:0]        op,
   input  logic              op_valid,
   input  logic              cin,
   input  logic [2:0]        ccr_mode,
   input  logic [7:0]        ccr_imm,
   input  logic              exc_entry,
   input  logic              irq_req,
   input  logic              nmi_req,
   output logic [DATA_W-1:0] result,
   output logic              result_we,
   output logic [7:0]        ccr,
   output logic              int_accept
);
   if ((DATA_W % 4) != 0 || DATA_W < 8) begin : g_bad_width
      $error("alu_flag_unit: DATA_W must be a multiple of 4 and at least 8");
   end
   if (HC_OFS + 1 >= DATA_W / 4) begin : g_bad_hcofs
      $error("alu_flag_unit: HC_OFS must leave room inside the byte lane");
   end

   logic sub, neg, cin_eff, upd, ext, h_upd;
   logic h, n, zero, v, c;

   afu_opdec u_dec (
      .op_i    (op),
      .size_i  (size),
      .valid_i (op_valid),
      .cin_i   (cin),
      .sub_o   (sub),
      .neg_o   (neg),
      .cin_o   (cin_eff),
      .we_o    (result_we),
      .upd_o   (upd),
      .ext_o   (ext),
      .h_upd_o (h_upd)
   );

   afu_arith #(.DATA_W(DATA_W), .HC_OFS(HC_OFS)) u_arith (
      .src_i  (src_op),
      .dst_i  (dst_op),
      .size_i (size),
      .sub_i  (sub),
      .neg_i  (neg),
      .cin_i  (cin_eff),
      .res_o  (result),
      .h_o    (h),
      .n_o    (n),
      .zero_o (zero),
      .v_o    (v),
      .c_o    (c)
   );

   afu_ccr u_ccr (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_i   (upd),
      .h_upd_i (h_upd),
      .ext_i   (ext),
      .h_i     (h),
      .n_i     (n),
      .zero_i  (zero),
      .v_i     (v),
      .c_i     (c),
      .wmode_i (ccr_mode),
      .imm_i   (ccr_imm),
      .exc_i   (exc_entry),
      .ccr_o   (ccr)
   );

   assign int_accept = nmi_req | (irq_req & ~ccr[BIT_I]);
endmodule

// File: rtl/afu_chk.sv
module afu_chk #(
   parameter int unsigned DATA_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] dst_op,
   input logic [1:0]        size,
   input logic [2:0]        op,
   input logic              op_valid,
   input logic [2:0]        ccr_mode,
   input logic [7:0]        ccr_imm,
   input logic              exc_entry,
   input logic              irq_req,
   input logic              nmi_req,
   input logic [DATA_W-1:0] result,
   input logic              result_we,
   input logic [7:0]        ccr,
   input logic              int_accept
);
   localparam int unsigned BW = DATA_W / 4;

   a_r1_reset_mask: assert property (@(posedge clk) !rst_n |=> ccr == 8'h80);

   a_r2_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && size == 2'd0) |-> result[DATA_W-1:BW] == dst_op[DATA_W-1:BW]);

   a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == 3'd4) |-> !result_we);

   a_r9_load_imm: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr_mode == 3'd1 && !exc_entry) |=> ccr == $past(ccr_imm));

   a_r9_user_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr_mode == 3'd0) |=> (ccr[6] == $past(ccr[6])) && (ccr[4] == $past(ccr[4])));

   a_r10_exc_sets_mask: assert property (@(posedge clk) disable iff (!rst_n)
      exc_entry |=> ccr[7]);

   a_r11_nmi_always: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |-> int_accept);

   a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr[7] && !nmi_req) |-> !int_accept);

   a_r11_open: assert property (@(posedge clk) disable iff (!rst_n)
      (!ccr[7] && irq_req) |-> int_accept);

   a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && ccr_mode == 3'd0 && !exc_entry) |=> $stable(ccr));
endmodule

bind alu_flag_unit afu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dst_op     (dst_op),
   .size       (size),
   .op         (op),
   .op_valid   (op_valid),
   .ccr_mode   (ccr_mode),
   .ccr_imm    (ccr_imm),
   .exc_entry  (exc_entry),
   .irq_req    (irq_req),
   .nmi_req    (nmi_req),
   .result     (result),
   .result_we  (result_we),
   .ccr        (ccr),
   .int_accept (int_accept)
);

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_op = '0, dst_op = '0;
   logic [1:0]  size = '0;
   logic [2:0]  op = 3'd7;
   logic        op_valid = 1'b0, cin = 1'b0;
   logic [2:0]  ccr_mode = '0;
   logic [7:0]  ccr_imm = '0;
   logic        exc_entry = 1'b0, irq_req = 1'b0, nmi_req = 1'b0;
   logic [31:0] result;
   logic        result_we;
   logic [7:0]  ccr;
   logic        int_accept;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_cc = 8'h80;

   always #10 clk = ~clk;

   alu_flag_unit u_dut (
      .clk(clk), .rst_n(rst_n), .src_op(src_op), .dst_op(dst_op), .size(size),
      .op(op), .op_valid(op_valid), .cin(cin), .ccr_mode(ccr_mode),
      .ccr_imm(ccr_imm), .exc_entry(exc_entry), .irq_req(irq_req),
      .nmi_req(nmi_req), .result(result), .result_we(result_we), .ccr(ccr),
      .int_accept(int_accept)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic longint sext(input longint unsigned val, input int w);
      longint s;
      s = longint'(val);
      if (val >= (64'd1 << (w - 1))) s = s - (64'sd1 <<< w);
      return s;
   endfunction

   // Reference: sized arithmetic from comparisons and exact signed sums
   task automatic model(input logic [2:0] mop, input logic [1:0] msz, input logic [31:0] s,
                        input logic [31:0] d, input logic mcin,
                        output logic [31:0] r, output logic we);
      int w;
      longint unsigned m, hm, a, b, ci, rv;
      longint sa, sb, ex;
      logic isx, issub, c, h, v, n, z;
      w     = (msz == 2'd0) ? 8 : (msz == 2'd1) ? 16 : 32;
      m     = (64'd1 << w) - 1;
      hm    = (64'd1 << (w - 4)) - 1;
      isx   = (mop == 3'd1) || (mop == 3'd3);
      issub = (mop == 3'd2) || (mop == 3'd3) || (mop == 3'd4) || (mop == 3'd5);
      ci    = isx ? longint'(mcin) : 0;
      a     = (mop == 3'd5) ? 0 : (longint'(d) & m);
      b     = (mop == 3'd5) ? (longint'(d) & m) : (longint'(s) & m);
      sa    = sext(a, w);
      sb    = sext(b, w);
      if (issub) begin
         c  = a < b + ci;
         h  = (a & hm) < (b & hm) + ci;
         rv = (a - b - ci) & m;
         ex = sa - sb - longint'(ci);
      end else begin
         c  = (a + b + ci) > m;
         h  = ((a & hm) + (b & hm) + ci) > hm;
         rv = (a + b + ci) & m;
         ex = sa + sb + longint'(ci);
      end
      v  = (ex > ((64'sd1 <<< (w - 1)) - 1)) || (ex < -(64'sd1 <<< (w - 1)));
      n  = rv[w-1];
      z  = (rv == 0);
      we = (mop != 3'd4);
      r  = (d & ~m[31:0]) | rv[31:0];
      if (msz == 2'd0 || !isx) exp_cc[5] = h;
      exp_cc[3] = n;
      if (isx) begin
         if (!z) exp_cc[2] = 1'b0;
      end else exp_cc[2] = z;
      exp_cc[1] = v;
      exp_cc[0] = c;
   endtask

   task automatic run_op(input string tag, input logic [2:0] o, input logic [1:0] sz,
                         input logic [31:0] s, input logic [31:0] d, input logic ci);
      logic [31:0] er;
      logic ewe;
      @(negedge clk);
      op = o; size = sz; src_op = s; dst_op = d; cin = ci; op_valid = 1'b1;
      #1;
      model(o, sz, s, d, ci, er, ewe);
      chk({tag, " R8 we"}, {31'd0, result_we}, {31'd0, ewe});
      if (ewe) chk({tag, " R2 result"}, result, er);
      @(posedge clk);
      #1;
      op_valid = 1'b0;
      chk({tag, " ccr R3 R4 R5 R6 R7"}, {24'd0, ccr}, {24'd0, exp_cc});
   endtask

   task automatic ccr_wr(input string tag, input logic [2:0] mode, input logic [7:0] imm,
                         input logic exc);
      @(negedge clk);
      ccr_mode = mode; ccr_imm = imm; exc_entry = exc;
      @(posedge clk);
      #1;
      ccr_mode = 3'd0; exc_entry = 1'b0;
      case (mode)
         3'd1: exp_cc = imm;
         3'd2: exp_cc = exp_cc & imm;
         3'd3: exp_cc = exp_cc | imm;
         3'd4: exp_cc = exp_cc ^ imm;
         default: ;
      endcase
      if (exc) exp_cc[7] = 1'b1;
      chk(tag, {24'd0, ccr}, {24'd0, exp_cc});
   endtask

   task automatic t_reset;
      irq_req = 1'b1;
      #1;
      chk("R1 reset ccr", {24'd0, ccr}, 32'h80);
      chk("R11 masked at reset", {31'd0, int_accept}, 32'd0);
      irq_req = 1'b0;
   endtask

   task automatic t_ccr_writes;
      ccr_wr("R9 load", 3'd1, 8'h00, 1'b0);
      ccr_wr("R9 or user bits", 3'd3, 8'h50, 1'b0);
      ccr_wr("R9 and", 3'd2, 8'h40, 1'b0);
      ccr_wr("R9 xor", 3'd4, 8'hFF, 1'b0);
      ccr_wr("R9 load clear", 3'd1, 8'h00, 1'b0);
   endtask

   task automatic t_interrupts;
      @(negedge clk);
      irq_req = 1'b1; nmi_req = 1'b0;
      #1 chk("R11 irq open", {31'd0, int_accept}, 32'd1);
      ccr_wr("R11 set UI", 3'd1, 8'h40, 1'b0);
      chk("R11 UI no mask", {31'd0, int_accept}, 32'd1);
      ccr_wr("R11 set I", 3'd1, 8'h80, 1'b0);
      chk("R11 irq masked", {31'd0, int_accept}, 32'd0);
      nmi_req = 1'b1;
      #1 chk("R11 nmi accepted", {31'd0, int_accept}, 32'd1);
      irq_req = 1'b0; nmi_req = 1'b0;
      ccr_wr("R9 reload", 3'd1, 8'h00, 1'b0);
   endtask

   task automatic t_arith;
      run_op("byte add overflow", 3'd0, 2'd0, 32'h0000_0001, 32'hA5A5_A57F, 1'b0);
      run_op("byte add carry zero", 3'd0, 2'd0, 32'h0000_0001, 32'h1234_56FF, 1'b0);
      run_op("word add half11", 3'd0, 2'd1, 32'h0000_0001, 32'hDEAD_0FFF, 1'b0);
      run_op("long add half27", 3'd0, 2'd2, 32'h0000_0001, 32'h0FFF_FFFF, 1'b0);
      run_op("byte sub borrow", 3'd2, 2'd0, 32'h0000_0001, 32'hFFFF_FF00, 1'b0);
      run_op("word sub overflow", 3'd2, 2'd1, 32'h0000_0001, 32'h1111_8000, 1'b0);
      run_op("byte neg min", 3'd5, 2'd0, 32'h0, 32'h0000_0080, 1'b0);
      run_op("long neg zero", 3'd5, 2'd3, 32'h0, 32'h0000_0000, 1'b0);
      run_op("long add overflow", 3'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
      run_op("word cmp equal", 3'd4, 2'd1, 32'h0000_1234, 32'hFFFF_1234, 1'b0);
      run_op("byte cmp less", 3'd4, 2'd0, 32'h0000_0010, 32'h0000_0008, 1'b0);
   endtask

   task automatic t_extend;
      ccr_wr("R6 preset Z", 3'd1, 8'h04, 1'b0);
      run_op("R6 addx zero keeps Z", 3'd1, 2'd0, 32'h0000_0000, 32'h0000_00FF, 1'b1);
      chk("R6 Z kept", {31'd0, ccr[2]}, 32'd1);
      run_op("R6 subx nonzero clears Z", 3'd3, 2'd0, 32'h0000_0001, 32'h0000_0005, 1'b1);
      run_op("R6 addx zero keeps clear", 3'd1, 2'd0, 32'h0, 32'h0, 1'b0);
      chk("R6 Z stays 0", {31'd0, ccr[2]}, 32'd0);
      ccr_wr("R4 preset H", 3'd1, 8'h20, 1'b0);
      run_op("R4 word addx H held", 3'd1, 2'd1, 32'h0000_0001, 32'h0000_0001, 1'b0);
      chk("R4 H unchanged", {31'd0, ccr[5]}, 32'd1);
      run_op("R4 byte subx H", 3'd3, 2'd0, 32'h0000_0001, 32'h0000_0010, 1'b0);
      chk("R4 byte subx borrow H", {31'd0, ccr[5]}, 32'd1);
   endtask

   task automatic t_priority;
      ccr_wr("R9 clear", 3'd1, 8'h00, 1'b0);
      @(negedge clk);
      op = 3'd0; size = 2'd0; src_op = 32'h1; dst_op = 32'hFF; op_valid = 1'b1;
      ccr_mode = 3'd1; ccr_imm = 8'h50;
      @(posedge clk);
      #1;
      op_valid = 1'b0; ccr_mode = 3'd0;
      exp_cc = 8'h50;
      chk("R9 write beats flags", {24'd0, ccr}, 32'h50);
      ccr_wr("R10 exc over load", 3'd1, 8'h00, 1'b1);
      ccr_wr("R9 clear again", 3'd1, 8'h00, 1'b0);
      ccr_wr("R10 exc alone", 3'd0, 8'h00, 1'b1);
   endtask

   task automatic t_hold;
      @(negedge clk);
      op = 3'd0; size = 2'd0; src_op = 32'hFF; dst_op = 32'h01; op_valid = 1'b0;
      #1 chk("R8 no we when idle", {31'd0, result_we}, 32'd0);
      @(posedge clk);
      #1 chk("R12 idle hold", {24'd0, ccr}, {24'd0, exp_cc});
      @(negedge clk);
      op = 3'd7; op_valid = 1'b1;
      #1 chk("R8 nop no we", {31'd0, result_we}, 32'd0);
      @(posedge clk);
      #1 chk("R12 nop hold", {24'd0, ccr}, {24'd0, exp_cc});
      op_valid = 1'b0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_ccr_writes();
      t_interrupts();
      t_arith();
      t_extend();
      t_priority();
      t_hold();
      repeat (2) @(posedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule